// File: doc/BRIEF.md
# Serial Memory Bus Slave Engine

This block is the protocol front end of a 2-Kbyte memory that sits on a two-wire serial bus. It oversamples the clock and data lines on a fast system clock and recognises the bus start and stop conditions. It decodes the select byte that opens every transfer. It then either receives a word address and write data, or streams read data back to the bus master. The data line is open-drain, so the engine only ever asks for it to be pulled low. The memory array, its address pointer, write buffering and the timing of internal write cycles belong to a back end, which the engine talks to through single-cycle strobes.

The select byte carries a fixed four-bit type code, three block bits and a direction bit. The block bits are not chip-select straps: they are handed to the back end as memory address bits [10:8]. While the back end reports a write cycle in progress, the engine leaves its select byte unacknowledged, which tells the master to poll. A write header followed by a repeated start and a read header gives a random read.

Top module: `sme_engine`

## Requirements
- R1: A falling data line while the clock line is high is a start condition, and a rising data line while the clock is high is a stop condition. Every stop produces exactly one `stop_o` pulse. Data-line changes while the clock is high are never taken as data bits.
- R2: The first byte after a start is the select byte. Its bits [7:4] must equal 4'b1010. Otherwise the select byte is not acknowledged, and no later byte is acknowledged or strobed until the next start.
- R3: On an accepted select byte, `hdr_stb_o` pulses once. Bits [3:1] of the byte appear on `blk_o`, and bit [0] appears on `rnw_o`, where 1 means read.
- R4: Bytes travel most significant bit first. An acknowledge keeps the data line low for the whole high phase of the ninth clock.
- R5: If `busy_i` is high when the last bit of the select byte is sampled, the select byte gets no acknowledge and the transfer is ignored until the next start.
- R6: In a write, the byte after the select byte is acknowledged and strobed on `waddr_stb_o`. Each later byte is acknowledged and strobed on `wdata_stb_o`. The byte value is on `byte_o` while its strobe is high.
- R7: In a read, `rd_data_i` is captured at the clock falling edge that opens each byte and is sent most significant bit first. A master acknowledge pulses `rd_ack_o` and the next byte follows. A master no-acknowledge pulses `rd_nak_o`, after which the data line stays released until the next start.
- R8: A repeated start after a write header, followed by a read select byte, switches the transfer to read without an intervening stop.
- R9: The data-line drive changes only while the synchronised clock line is low. Each change comes at least one system clock after the falling edge is detected.
- R10: A start or stop in the middle of a byte abandons that byte. No strobe is issued for it, and a select byte after the start is decoded from its first bit.
- R11: After reset the data line is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_i | input | 1 | Back end is in a write cycle |
| rd_data_i | input | 8 | Byte at the back end's current address |
| hdr_stb_o | output | 1 | Accepted select byte |
| blk_o | output | 3 | Block bits, memory address [10:8] |
| rnw_o | output | 1 | Direction of the accepted select byte, 1 = read |
| waddr_stb_o | output | 1 | Word address byte received |
| wdata_stb_o | output | 1 | Write data byte received |
| byte_o | output | 8 | Received byte qualified by the two strobes above |
| rd_ack_o | output | 1 | Master acknowledged a read byte |
| rd_nak_o | output | 1 | Master declined a read byte |
| stop_o | output | 1 | Stop condition seen |

## Verification
A bit counter that is out of step with the bus puts an acknowledge in the wrong clock. A master that samples the ninth bit sees no acknowledge at the end of the very next byte. It also sees an acknowledge that wanders into the data bits of a read. A wrong state after the select byte shows up within one byte time: either the wrong strobe fires or read data appears where the master expects an address acknowledge. A stale transmit bit or a late drive update corrupts the read byte the master assembles, so the full sweep of blocks and addresses, compared against arithmetic expectations, catches it in the byte where it happens.

// File: rtl/sme_pkg.sv
// Shared widths and the engine state type for the serial memory bus slave.
package sme_pkg;
    localparam int BYTE_W = 8;                        // bits per bus byte
    localparam int TYPE_W = 4;                        // type-code field width
    localparam int BLK_W  = BYTE_W - TYPE_W - 1;      // block bits in select byte
    localparam int IDX_W  = $clog2(BYTE_W);           // bit index width
    localparam int CNT_W  = $clog2(BYTE_W + 1);       // counts data bits plus ack slot

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer in progress
        ST_SEL,    // receiving select byte
        ST_ADDR,   // receiving word address
        ST_WR,     // receiving write data
        ST_RD,     // transmitting read data
        ST_SKIP    // not addressed, wait for next start
    } eng_state_t;
endpackage

// File: rtl/sme_sync.sv
// Line synchroniser and bus-condition detector.
// Brings both bus lines into the clk domain through STAGES flops, keeps one
// more delayed copy, and flags clock edges and start/stop conditions.
// Assumes clk runs at least 8x the bus bit rate, so a condition lasts several cycles.
module sme_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_prev;
    logic            sda_prev;

    // Shift both lines through the synchroniser; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    // Decode edges and conditions from the current and previous samples.
    always_comb begin
        scl_lvl  = scl_pipe[STAGES-1];
        sda_lvl  = sda_pipe[STAGES-1];
        scl_prev = scl_pipe[STAGES];
        sda_prev = sda_pipe[STAGES];
        scl_rise = scl_lvl & ~scl_prev;
        scl_fall = ~scl_lvl & scl_prev;
        start_p  = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_p   = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

    // R1: a condition needs the clock high on both samples.
    a_r1_cond_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p || stop_p) |-> (scl_lvl && !scl_rise));
endmodule

// File: rtl/sme_shift.sv
// Byte shifter: collects received bits MSB first and holds the byte being sent.
// The received byte including the bit on the line is offered combinationally,
// so the controller can decide on the same edge that samples the last bit.
module sme_shift
    import sme_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sda_lvl,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic [IDX_W-1:0]  tx_idx,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_bit
);
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;

    // Receive shift register, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (shift_en) rx_q <= {rx_q[BYTE_W-2:0], sda_lvl};
    end

    // Transmit holding register, loaded once per read byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (tx_load) tx_q <= tx_data;
    end

    // Expose the byte as it will be after the current bit and the selected tx bit.
    always_comb begin
        rx_byte = {rx_q[BYTE_W-2:0], sda_lvl};
        tx_bit  = tx_q[tx_idx];
    end
endmodule

// File: rtl/sme_drive.sv
// Open-drain data-line driver with hold delay.
// A request made at a detected clock fall is applied HOLD_CLKS cycles later,
// keeping data-line changes inside the clock low phase. Start and stop
// release the line at once. Assumes the clock low phase exceeds the delay.
module sme_drive #(
    parameter int HOLD_CLKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic req,
    input  logic nxt,
    input  logic rel,
    output logic sda_oe
);
    localparam int HW = (HOLD_CLKS < 2) ? 1 : $clog2(HOLD_CLKS);

    logic          pend;
    logic          val;
    logic [HW-1:0] cnt;

    // Hold the requested level until the delay expires, then drive it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            pend   <= 1'b0;
            val    <= 1'b0;
            cnt    <= '0;
        end else if (rel) begin
            sda_oe <= 1'b0;
            pend   <= 1'b0;
        end else if (req) begin
            pend <= 1'b1;
            val  <= nxt;
            cnt  <= HW'(HOLD_CLKS - 1);
        end else if (pend) begin
            if (cnt == '0) begin
                sda_oe <= val;
                pend   <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R9: the drive level moves only while the synchronised clock is low.
    a_r9_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);
    // R9: a drive update never lands on the cycle of its request.
    a_r9_not_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rel) |=> $stable(sda_oe));
endmodule

// File: rtl/sme_ctrl.sv
// Transfer controller: tracks bit position, decodes select and address bytes,
// schedules acknowledges and read bits, and issues back-end strobes.
// Assumes one clk-domain event per cycle from sme_sync (edges and conditions
// are mutually exclusive) and a back end that updates rd_data_i within the
// clock high phase that follows rd_ack_o.
module sme_ctrl
    import sme_pkg::*;
#(
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_lvl,
    input  logic              sda_oe,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic              tx_bit,
    output logic              shift_en,
    output logic              tx_load,
    output logic [IDX_W-1:0]  tx_idx,
    output logic              drv_req,
    output logic              drv_nxt,
    output logic              drv_rel,
    output logic              hdr_stb,
    output logic [BLK_W-1:0]  blk,
    output logic              rnw,
    output logic              waddr_stb,
    output logic              wdata_stb,
    output logic [BYTE_W-1:0] byte_q,
    output logic              rd_ack,
    output logic              rd_nak,
    output logic              stop_stb
);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    eng_state_t       st;
    logic [CNT_W-1:0] bitcnt;
    logic             ack_due;
    logic             active_rise;
    logic             byte_done;
    logic             slot_rise;
    logic             type_ok;

    // Classify the current rising edge.
    always_comb begin
        active_rise = scl_rise && (st != ST_IDLE) && !start_p && !stop_p;
        byte_done   = active_rise && (bitcnt == LAST_BIT);
        slot_rise   = active_rise && (bitcnt == ACK_SLOT);
        type_ok     = (rx_byte[BYTE_W-1 -: TYPE_W] == TYPE_CODE);
        shift_en    = active_rise && (bitcnt < ACK_SLOT);
    end

    // Bit position, transfer state, acknowledge scheduling and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            ack_due   <= 1'b0;
            hdr_stb   <= 1'b0;
            blk       <= '0;
            rnw       <= 1'b0;
            waddr_stb <= 1'b0;
            wdata_stb <= 1'b0;
            byte_q    <= '0;
            rd_ack    <= 1'b0;
            rd_nak    <= 1'b0;
            stop_stb  <= 1'b0;
        end else begin
            hdr_stb   <= 1'b0;
            waddr_stb <= 1'b0;
            wdata_stb <= 1'b0;
            rd_ack    <= 1'b0;
            rd_nak    <= 1'b0;
            stop_stb  <= 1'b0;
            if (start_p) begin
                st      <= ST_SEL;
                bitcnt  <= '0;
                ack_due <= 1'b0;
            end else if (stop_p) begin
                st       <= ST_IDLE;
                bitcnt   <= '0;
                ack_due  <= 1'b0;
                stop_stb <= 1'b1;
            end else if (slot_rise) begin
                bitcnt  <= '0;
                ack_due <= 1'b0;
                if (st == ST_RD && !ack_due) begin
                    if (sda_lvl) begin
                        rd_nak <= 1'b1;
                        st     <= ST_SKIP;
                    end else begin
                        rd_ack <= 1'b1;
                    end
                end
            end else if (active_rise) begin
                bitcnt <= bitcnt + 1'b1;
                if (byte_done) begin
                    case (st)
                        ST_SEL: begin
                            if (type_ok && !busy_i) begin
                                ack_due <= 1'b1;
                                hdr_stb <= 1'b1;
                                blk     <= rx_byte[BLK_W:1];
                                rnw     <= rx_byte[0];
                                st      <= rx_byte[0] ? ST_RD : ST_ADDR;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                        ST_ADDR: begin
                            ack_due   <= 1'b1;
                            waddr_stb <= 1'b1;
                            byte_q    <= rx_byte;
                            st        <= ST_WR;
                        end
                        ST_WR: begin
                            ack_due   <= 1'b1;
                            wdata_stb <= 1'b1;
                            byte_q    <= rx_byte;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Choose the data-line level for the coming low phase at each clock fall.
    always_comb begin
        drv_rel = start_p || stop_p;
        drv_req = scl_fall && (st != ST_IDLE);
        tx_load = scl_fall && (st == ST_RD) && (bitcnt == '0);
        tx_idx  = IDX_W'(BYTE_W - 1) - bitcnt[IDX_W-1:0];
        if (bitcnt == ACK_SLOT)
            drv_nxt = ack_due;
        else if (st == ST_RD && bitcnt == '0)
            drv_nxt = ~rd_data_i[BYTE_W-1];
        else if (st == ST_RD)
            drv_nxt = ~tx_bit;
        else
            drv_nxt = 1'b0;
    end

    // R2: a wrong type code sends the transfer to the ignore state.
    a_r2_bad_type_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_SEL && !type_ok) |=> (st == ST_SKIP && !ack_due));
    // R5: busy blocks the select acknowledge and the header strobe.
    a_r5_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_SEL && busy_i) |=> (!ack_due && !hdr_stb));
    // R4: the line is held low when the master samples an acknowledge.
    a_r4_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_rise && ack_due) |-> sda_oe);
    // R10: start always restarts byte counting in select state.
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> (bitcnt == '0 && st == ST_SEL && !ack_due));
    // R6: back-end strobes never overlap.
    a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_stb, waddr_stb, wdata_stb, rd_ack, rd_nak, stop_stb}));
    // R2: once ignoring, no byte is strobed.
    a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP && $past(st) == ST_SKIP) |-> !(hdr_stb || waddr_stb || wdata_stb || rd_ack));
    // R4: the bit position never passes the acknowledge slot.
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= ACK_SLOT);
endmodule

// File: rtl/sme_engine.sv
// Serial memory bus slave engine, top level.
// Joins the synchroniser, byte shifter, controller and open-drain driver.
// Assumes an external back end holds the memory and address pointer, and
// that clk is at least 8x the bus bit rate.
module sme_engine
    import sme_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                HOLD_CLKS   = 1,
    parameter logic [TYPE_W-1:0] TYPE_CODE   = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              hdr_stb_o,
    output logic [BLK_W-1:0]  blk_o,
    output logic              rnw_o,
    output logic              waddr_stb_o,
    output logic              wdata_stb_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              rd_ack_o,
    output logic              rd_nak_o,
    output logic              stop_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;
    logic              shift_en, tx_load, tx_bit;
    logic [IDX_W-1:0]  tx_idx;
    logic [BYTE_W-1:0] rx_byte;
    logic              drv_req, drv_nxt, drv_rel;

    sme_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
    );

    sme_shift u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sda_lvl(sda_lvl),
        .tx_load(tx_load), .tx_data(rd_data_i), .tx_idx(tx_idx),
        .rx_byte(rx_byte), .tx_bit(tx_bit)
    );

    sme_ctrl #(.TYPE_CODE(TYPE_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl), .sda_oe(sda_oe_o),
        .busy_i(busy_i), .rx_byte(rx_byte), .rd_data_i(rd_data_i), .tx_bit(tx_bit),
        .shift_en(shift_en), .tx_load(tx_load), .tx_idx(tx_idx),
        .drv_req(drv_req), .drv_nxt(drv_nxt), .drv_rel(drv_rel),
        .hdr_stb(hdr_stb_o), .blk(blk_o), .rnw(rnw_o),
        .waddr_stb(waddr_stb_o), .wdata_stb(wdata_stb_o), .byte_q(byte_o),
        .rd_ack(rd_ack_o), .rd_nak(rd_nak_o), .stop_stb(stop_o)
    );

    sme_drive #(.HOLD_CLKS(HOLD_CLKS)) u_drive (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .req(drv_req),
        .nxt(drv_nxt), .rel(drv_rel), .sda_oe(sda_oe_o)
    );
endmodule

// File: tb/sim_sme_engine.sv
// Bench: a bus master built from tasks, a behavioural back end, and
// arithmetic expectations for every acknowledge, strobe and read byte.
module sim_sme_engine;
    localparam int CLK_NS = 10;
    localparam int Q      = 8;     // system clocks per quarter bit

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic       rst_n, scl_m, sda_m, busy;
    logic       sda_oe, sda_bus;
    logic [7:0] rd_data, byte_o;
    logic [2:0] blk_o;
    logic       hdr_stb, rnw_o, waddr_stb, wdata_stb, rd_ack, rd_nak, stop_o;

    assign sda_bus = sda_m & ~sda_oe;

    sme_engine u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .busy_i(busy), .rd_data_i(rd_data), .hdr_stb_o(hdr_stb), .blk_o(blk_o),
        .rnw_o(rnw_o), .waddr_stb_o(waddr_stb), .wdata_stb_o(wdata_stb),
        .byte_o(byte_o), .rd_ack_o(rd_ack), .rd_nak_o(rd_nak), .stop_o(stop_o)
    );

    // Behavioural back end: memory plus pointer driven by the strobes.
    logic [7:0]  mem [0:2047];
    logic [10:0] ptr;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'(i * 37 + 5);
            ptr <= '0;
        end else if (hdr_stb) ptr[10:8] <= blk_o;
        else if (waddr_stb) ptr[7:0] <= byte_o;
        else if (wdata_stb) begin
            mem[ptr] <= byte_o;
            ptr[4:0] <= ptr[4:0] + 5'd1;
        end else if (rd_ack || rd_nak) ptr <= ptr + 11'd1;
    end
    assign rd_data = mem[ptr];

    // Strobe monitor.
    int n_hdr = 0, n_waddr = 0, n_wdata = 0, n_rdack = 0, n_rdnak = 0, n_stop = 0;
    logic [7:0] last_waddr = '0;
    logic [2:0] last_blk = '0;
    logic       last_rnw = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (hdr_stb) begin n_hdr++; last_blk = blk_o; last_rnw = rnw_o; end
            if (waddr_stb) begin n_waddr++; last_waddr = byte_o; end
            if (wdata_stb) n_wdata++;
            if (rd_ack) n_rdack++;
            if (rd_nak) n_rdnak++;
            if (stop_o) n_stop++;
        end
    end

    // R9 monitor: drive level may change only while the bus clock is low.
    int   viol = 0;
    logic prev_oe = 1'b0;
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
        prev_oe <= sda_oe;
    end

    int tests = 0, fails = 0, unstable = 0, stops_sent = 0;
    logic [7:0] exp_mem [0:2047];

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
        stops_sent++;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus; qwait();
        if (sda_bus !== b) unstable++;
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic l;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(l);
        ack = !l;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic l;
        for (int i = 7; i >= 0; i--) begin get_bit(l); v[i] = l; end
        put_bit(!give_ack);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        chk("WDOG", "run finished in time", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        int         hs;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0;
        for (int i = 0; i < 2048; i++) exp_mem[i] = 8'(i * 37 + 5);
        repeat (5) @(negedge clk);
        chk("R11", "oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11", "oe after reset", int'(sda_oe), 0);
        chk("R11", "strobes after reset", n_hdr + n_waddr + n_wdata + n_stop, 0);

        // R2 / R3: sweep every type code with block 5, write direction.
        for (int t = 0; t < 16; t++) begin
            hs = n_waddr;
            bus_start();
            send_byte({4'(t), 3'd5, 1'b0}, ack);
            chk("R2", $sformatf("select ack type %0d", t), int'(ack), int'(t == 10));
            if (t == 10) chk("R3", "block bits", int'(last_blk), 5);
            else begin
                send_byte(8'h44, ack);
                chk("R2", "later byte ignored", int'(ack), 0);
                chk("R2", "no address strobe", n_waddr, hs);
            end
            bus_stop();
        end

        // R6 / R3 / R7 / R8: write two bytes then random-read three, per block.
        for (int b = 0; b < 8; b++) begin
            logic [7:0]  wa, d0;
            logic [10:0] a;
            wa = (b == 7) ? 8'hFE : 8'(b * 29 + 6);
            d0 = 8'(b * 13 + 8'h5A);
            hs = n_wdata;
            bus_start();
            send_byte({4'hA, 3'(b), 1'b0}, ack);
            chk("R3", "write select ack", int'(ack), 1);
            chk("R3", "block on header", int'(last_blk), b);
            chk("R3", "direction write", int'(last_rnw), 0);
            send_byte(wa, ack);
            chk("R6", "address ack", int'(ack), 1);
            chk("R6", "address strobe value", int'(last_waddr), int'(wa));
            send_byte(d0, ack);
            chk("R6", "data0 ack", int'(ack), 1);
            send_byte(~d0, ack);
            chk("R6", "data1 ack", int'(ack), 1);
            bus_stop();
            chk("R6", "data strobes", n_wdata - hs, 2);
            exp_mem[{3'(b), wa[7:5], wa[4:0]}] = d0;
            exp_mem[{3'(b), wa[7:5], 5'(wa[4:0] + 5'd1)}] = ~d0;

            hs = n_rdack;
            bus_start();
            send_byte({4'hA, 3'(b), 1'b0}, ack);
            send_byte(wa, ack);
            bus_start();
            send_byte({4'hA, 3'(b), 1'b1}, ack);
            chk("R8", "read select ack after repeated start", int'(ack), 1);
            chk("R3", "direction read", int'(last_rnw), 1);
            for (int k = 0; k < 3; k++) begin
                a = {3'(b), wa} + 11'(k);
                recv_byte(k < 2, v);
                chk("R7", $sformatf("read byte %0d blk %0d", k, b), int'(v), int'(exp_mem[a]));
            end
            chk("R7", "master acks seen", n_rdack - hs, 2);
            bus_stop();
        end

        // R7: current-address read in block 3; pointer low byte is 0x01 after the wrap.
        hs = n_rdnak;
        bus_start();
        send_byte({4'hA, 3'd3, 1'b1}, ack);
        chk("R7", "current read select ack", int'(ack), 1);
        recv_byte(1'b0, v);
        chk("R7", "current read byte", int'(v), int'(exp_mem[11'h301]));
        chk("R7", "no-ack strobe", n_rdnak - hs, 1);
        hs = 0;
        for (int k = 0; k < 9; k++) begin
            logic l;
            get_bit(l);
            hs += int'(l);
        end
        chk("R7", "line released after no-ack", hs, 9);
        bus_stop();

        // R5: busy blocks the select acknowledge.
        busy = 1'b1;
        hs = n_waddr;
        bus_start();
        send_byte({4'hA, 3'd0, 1'b0}, ack);
        chk("R5", "select while busy", int'(ack), 0);
        send_byte(8'h12, ack);
        chk("R5", "byte after busy select", int'(ack), 0);
        chk("R5", "no address strobe while busy", n_waddr, hs);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte({4'hA, 3'd0, 1'b0}, ack);
        chk("R5", "select after busy clears", int'(ack), 1);
        bus_stop();

        // R10: start in mid-byte, then stop in mid-byte.
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte({4'hA, 3'd1, 1'b0}, ack);
        chk("R10", "select after mid-byte start", int'(ack), 1);
        send_byte(8'h33, ack);
        chk("R10", "address after abort", int'(last_waddr), 8'h33);
        hs = n_wdata;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        chk("R10", "no data strobe for cut byte", n_wdata, hs);
        bus_start();
        send_byte({4'hA, 3'd1, 1'b1}, ack);
        chk("R10", "select after mid-byte stop", int'(ack), 1);
        recv_byte(1'b0, v);
        bus_stop();

        repeat (4 * Q) @(negedge clk);
        chk("R1", "stop pulses", n_stop, stops_sent);
        chk("R9", "drive changes with clock high", viol, 0);
        chk("R4", "line moved during clock high", unstable, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule